// File: doc/BRIEF.md
# GPIO Interrupt Sense and Status Unit

This block watches a bank of general-purpose input pins and turns their activity into interrupt requests. Each pin has its own trigger type: rising edge, falling edge, either edge, high level or low level. Pins are brought into the local clock domain by a synchroniser before any detection. Edge events are caught in a sticky status bit that software clears by writing a one. Level conditions are reported live for as long as they last.

A small 32-bit register bus gives access to the per-pin enable, trigger-type and mask settings. The same bus reads back the raw and masked status and accepts the clear writes. All masked status bits are combined into a single request line to the parent interrupt controller. A mask bit of one blocks its pin. Enable and mask are separate controls: enable decides whether the pin records status at all, and mask only gates what reaches the output. For edge detection, the either-edge setting takes priority over the polarity setting.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads as zero and `irq_o` is 0.
- R2: Writable settings sit at byte offsets enable 0x18, sense 0x1C, either-edge 0x20, polarity 0x24 and mask 0x2C, and read back what was written. Raw status reads at 0x28 and masked status at 0x30. Writes to either status offset change nothing.
- R3: Pins pass through a two-stage synchroniser. A pin change made between clock edges shows as edge status after the third following rising clock edge and as level status after the second.
- R4: With sense bit 0 and either-edge bit 0, polarity 1 latches status on a 0-to-1 pin transition only, and polarity 0 latches it on a 1-to-0 transition only.
- R5: With sense bit 0 and either-edge bit 1, both transitions latch status, whatever the polarity bit holds.
- R6: With sense bit 1, raw status is 1 while the synchronised pin equals the polarity bit (1 means high, 0 means low). The either-edge bit has no effect, and a clear write does not remove the status while the level persists.
- R7: Latched edge status stays set until a 1 is written to that pin's bit at the clear offset 0x34. Zero bits in that write leave status unchanged, and offset 0x34 reads as zero.
- R8: A pin whose enable bit is 0 shows no raw status. Edges seen while it is disabled are not recorded, and clearing the enable bit discards any status already latched.
- R9: A mask bit of 1 removes that pin from the masked status (0x30) and from `irq_o`. Its raw status is unaffected.
- R10: Masked status equals raw AND enable AND NOT mask, and `irq_o` is 1 exactly when any masked status bit is 1.
- R11: When a new edge event and a clear for the same pin fall in the same cycle, the event wins and the status remains set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPIN | Asynchronous pin levels |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | AW | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from address while selected |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same clock cycle as a fresh edge on the same pin. Getting there requires the write to be aligned to the one cycle in which the delayed pin copy and its previous value disagree. The bench first latches status on an either-edge pin, then toggles that pin between clock edges and lets two rising edges pass. It then issues the clear so that it is captured on the third edge, exactly when the detector raises the new event. The status must remain set, and only a later, separate clear may drop it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Byte offsets decoded by software drivers
   localparam logic [7:0] OFF_ENABLE = 8'h18;
   localparam logic [7:0] OFF_SENSE  = 8'h1C;
   localparam logic [7:0] OFF_BOTH   = 8'h20;
   localparam logic [7:0] OFF_POL    = 8'h24;
   localparam logic [7:0] OFF_RAW    = 8'h28;
   localparam logic [7:0] OFF_MASK   = 8'h2C;
   localparam logic [7:0] OFF_MSTAT  = 8'h30;
   localparam logic [7:0] OFF_CLEAR  = 8'h34;

   // Index of each writable setting inside the register file
   localparam int CFG_ENABLE = 0;
   localparam int CFG_SENSE  = 1;
   localparam int CFG_BOTH   = 2;
   localparam int CFG_POL    = 3;
   localparam int CFG_MASK   = 4;
   localparam int NUM_CFG    = 5;

   function automatic logic [7:0] cfg_offset(input int idx);
      case (idx)
         CFG_ENABLE: cfg_offset = OFF_ENABLE;
         CFG_SENSE:  cfg_offset = OFF_SENSE;
         CFG_BOTH:   cfg_offset = OFF_BOTH;
         CFG_POL:    cfg_offset = OFF_POL;
         default:    cfg_offset = OFF_MASK;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];

   // Cycles since reset, saturating, so the latency check never looks before reset
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              age_q <= '0;
      else if (age_q != 2'd2)  age_q <= age_q + 2'd1;
   end

   generate
      if (STAGES == 2) begin : g_lat_chk
         // R3
         sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_i,
   input  logic [W-1:0] en_i,
   input  logic [W-1:0] sense_i,
   input  logic [W-1:0] both_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] raw_o
);

   logic [W-1:0] prev_q;
   logic [W-1:0] lat_q;
   logic [W-1:0] evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         logic rise, fall, lvl_hit;

         assign rise    = sync_i[i] & ~prev_q[i];
         assign fall    = ~sync_i[i] & prev_q[i];
         // either-edge overrides the polarity choice
         assign evt[i]  = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
         assign lvl_hit = (sync_i[i] == pol_i[i]);

         // new event has priority over a simultaneous clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lat_q[i] <= 1'b0;
            else        lat_q[i] <= en_i[i] & ~sense_i[i] & (evt[i] | (lat_q[i] & ~clr_i[i]));
         end

         assign raw_o[i] = en_i[i] & (sense_i[i] ? lvl_hit : lat_q[i]);

         // R7
         sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lat_q[i] && en_i[i] && !sense_i[i] && !clr_i[i]) |=> lat_q[i]);
         // R7
         clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt[i]) |=> !lat_q[i]);
         // R11
         event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[i] && en_i[i] && !sense_i[i]) |=> lat_q[i]);
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int W  = 32,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_i,
   input  logic          wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic [31:0]   wdata_i,
   input  logic [W-1:0]  raw_i,
   input  logic [W-1:0]  mstat_i,
   output logic [W-1:0]  en_o,
   output logic [W-1:0]  sense_o,
   output logic [W-1:0]  both_o,
   output logic [W-1:0]  pol_o,
   output logic [W-1:0]  mask_o,
   output logic [W-1:0]  clr_o,
   output logic [31:0]   rdata_o
);

   generate
      if (W < 1 || W > 32) begin : g_bad_w
         $error("gpio_irq_regs: W must be 1..32");
      end
      if (AW < 6) begin : g_bad_aw
         $error("gpio_irq_regs: AW must be at least 6");
      end
   endgenerate

   logic [W-1:0] cfg_q [NUM_CFG];
   logic         wr_hit;

   assign wr_hit = sel_i & wr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NUM_CFG; k++) cfg_q[k] <= '0;
      end else if (wr_hit) begin
         for (int k = 0; k < NUM_CFG; k++)
            if (addr_i == AW'(cfg_offset(k))) cfg_q[k] <= wdata_i[W-1:0];
      end
   end

   assign en_o    = cfg_q[CFG_ENABLE];
   assign sense_o = cfg_q[CFG_SENSE];
   assign both_o  = cfg_q[CFG_BOTH];
   assign pol_o   = cfg_q[CFG_POL];
   assign mask_o  = cfg_q[CFG_MASK];
   assign clr_o   = (wr_hit && addr_i == AW'(OFF_CLEAR)) ? wdata_i[W-1:0] : '0;

   always_comb begin
      rdata_o = '0;
      if (sel_i) begin
         for (int k = 0; k < NUM_CFG; k++)
            if (addr_i == AW'(cfg_offset(k))) rdata_o = 32'(cfg_q[k]);
         if (addr_i == AW'(OFF_RAW))   rdata_o = 32'(raw_i);
         if (addr_i == AW'(OFF_MSTAT)) rdata_o = 32'(mstat_i);
      end
   end

   // R7
   clear_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i && addr_i == AW'(OFF_CLEAR)) |-> (rdata_o == 32'd0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int NPIN        = 32,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_i,
   input  logic            bus_sel_i,
   input  logic            bus_wr_i,
   input  logic [AW-1:0]   bus_addr_i,
   input  logic [31:0]     bus_wdata_i,
   output logic [31:0]     bus_rdata_o,
   output logic            irq_o
);

   logic [NPIN-1:0] pin_s;
   logic [NPIN-1:0] en_w, sense_w, both_w, pol_w, mask_w, clr_w;
   logic [NPIN-1:0] raw_w, mstat_w;

   gpio_irq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   gpio_irq_detect #(.W(NPIN)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (pin_s),
      .en_i    (en_w),
      .sense_i (sense_w),
      .both_i  (both_w),
      .pol_i   (pol_w),
      .clr_i   (clr_w),
      .raw_o   (raw_w)
   );

   gpio_irq_regs #(.W(NPIN), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (bus_sel_i),
      .wr_i    (bus_wr_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .raw_i   (raw_w),
      .mstat_i (mstat_w),
      .en_o    (en_w),
      .sense_o (sense_w),
      .both_o  (both_w),
      .pol_o   (pol_w),
      .mask_o  (mask_w),
      .clr_o   (clr_w),
      .rdata_o (bus_rdata_o)
   );

   assign mstat_w = raw_w & en_w & ~mask_w;
   assign irq_o   = |mstat_w;

   // R9
   full_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_w) |-> !irq_o);
   // R8
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w == '0) |-> (!irq_o && raw_w == '0));

endmodule

// File: tb/sim_gpio_irq_unit.sv
module sim_gpio_irq_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_EN = 8'h18, A_SEN = 8'h1C, A_BOTH = 8'h20, A_POL = 8'h24;
   localparam logic [7:0] A_RAW = 8'h28, A_MASK = 8'h2C, A_MST = 8'h30, A_CLR = 8'h34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = '0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_irq_unit u0 (
      .clk(clk), .rst_n(rst_n), .pin_i(pins),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      sel = 1'b0; wr = 1'b0; wdata = '0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1;
      d = rdata;
      sel = 1'b0;
   endtask

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd_reg(a, d);
      chk(req, $sformatf("reg %h", a), d, exp);
   endtask

   task automatic cleanup();
      pins = '0;
      tick(4);
      wr_reg(A_EN, '0); wr_reg(A_SEN, '0); wr_reg(A_BOTH, '0);
      wr_reg(A_POL, '0); wr_reg(A_MASK, '0); wr_reg(A_CLR, '1);
      tick(1);
   endtask

   task automatic t_reset();
      chk_reg("R1", A_EN, 0);   chk_reg("R1", A_SEN, 0);  chk_reg("R1", A_BOTH, 0);
      chk_reg("R1", A_POL, 0);  chk_reg("R1", A_RAW, 0);  chk_reg("R1", A_MASK, 0);
      chk_reg("R1", A_MST, 0);  chk_reg("R1", A_CLR, 0);
      chk("R1", "irq", 32'(irq), 0);
   endtask

   task automatic t_regmap();
      wr_reg(A_SEN, 32'h1234_5678); wr_reg(A_BOTH, 32'h0F0F_A5A5);
      wr_reg(A_POL, 32'hDEAD_BEEF); wr_reg(A_MASK, 32'h8000_0001);
      wr_reg(A_RAW, 32'hFFFF_FFFF); wr_reg(A_MST, 32'hFFFF_FFFF);
      chk_reg("R2", A_SEN, 32'h1234_5678); chk_reg("R2", A_BOTH, 32'h0F0F_A5A5);
      chk_reg("R2", A_POL, 32'hDEAD_BEEF); chk_reg("R2", A_MASK, 32'h8000_0001);
      chk_reg("R2", A_RAW, 0);             chk_reg("R2", A_MST, 0);
      wr_reg(A_EN, 32'hC001_0000);
      chk_reg("R2", A_EN, 32'hC001_0000);
      cleanup();
   endtask

   task automatic t_sync();
      wr_reg(A_POL, 32'h3); wr_reg(A_SEN, 32'h2); wr_reg(A_EN, 32'h3);
      pins[0] = 1'b1;
      tick(2); chk_reg("R3", A_RAW, 0);
      tick(1); chk_reg("R3", A_RAW, 32'h1);
      pins[1] = 1'b1;
      tick(1); chk_reg("R3", A_RAW, 32'h1);
      tick(1); chk_reg("R3", A_RAW, 32'h3);
      cleanup();
   endtask

   task automatic t_edges();
      wr_reg(A_POL, 32'h4); wr_reg(A_EN, 32'hC);
      pins[3:2] = 2'b11;
      tick(4); chk_reg("R4", A_RAW, 32'h4);
      wr_reg(A_CLR, 32'hC);
      pins[3:2] = 2'b00;
      tick(4); chk_reg("R4", A_RAW, 32'h8);
      cleanup();
   endtask

   task automatic t_both();
      wr_reg(A_BOTH, 32'h30); wr_reg(A_POL, 32'h10); wr_reg(A_EN, 32'h30);
      pins[5:4] = 2'b11;
      tick(4); chk_reg("R5", A_RAW, 32'h30);
      wr_reg(A_CLR, 32'h30);
      tick(1); chk_reg("R5", A_RAW, 0);
      pins[5:4] = 2'b00;
      tick(4); chk_reg("R5", A_RAW, 32'h30);
      cleanup();
   endtask

   task automatic t_level();
      wr_reg(A_SEN, 32'hC0); wr_reg(A_BOTH, 32'hC0); wr_reg(A_POL, 32'h40); wr_reg(A_EN, 32'hC0);
      tick(1); chk_reg("R6", A_RAW, 32'h80);
      wr_reg(A_CLR, 32'hC0);
      tick(1); chk_reg("R6", A_RAW, 32'h80);
      pins[7:6] = 2'b11;
      tick(4); chk_reg("R6", A_RAW, 32'h40);
      pins[7:6] = 2'b00;
      tick(4); chk_reg("R6", A_RAW, 32'h80);
      cleanup();
   endtask

   task automatic t_w1c();
      wr_reg(A_POL, 32'h300); wr_reg(A_EN, 32'h300);
      pins[9:8] = 2'b11;
      tick(4); chk_reg("R7", A_RAW, 32'h300);
      tick(6); chk_reg("R7", A_RAW, 32'h300);
      wr_reg(A_CLR, 32'h0);
      tick(1); chk_reg("R7", A_RAW, 32'h300);
      wr_reg(A_CLR, 32'h100);
      tick(1); chk_reg("R7", A_RAW, 32'h200);
      chk_reg("R7", A_CLR, 0);
      cleanup();
   endtask

   task automatic t_enable();
      wr_reg(A_POL, 32'h400);
      pins[10] = 1'b1;
      tick(4); chk_reg("R8", A_RAW, 0);
      chk("R8", "irq disabled", 32'(irq), 0);
      wr_reg(A_EN, 32'h400);
      tick(2); chk_reg("R8", A_RAW, 0);
      pins[10] = 1'b0; tick(4);
      pins[10] = 1'b1; tick(4);
      chk_reg("R8", A_RAW, 32'h400);
      wr_reg(A_EN, 32'h0); tick(1);
      chk_reg("R8", A_RAW, 0);
      wr_reg(A_EN, 32'h400); tick(1);
      chk_reg("R8", A_RAW, 0);
      cleanup();
   endtask

   task automatic t_mask();
      wr_reg(A_POL, 32'h800); wr_reg(A_MASK, 32'h800); wr_reg(A_EN, 32'h800);
      pins[11] = 1'b1;
      tick(4);
      chk_reg("R9", A_RAW, 32'h800);
      chk_reg("R9", A_MST, 0);
      chk("R9", "irq masked", 32'(irq), 0);
      wr_reg(A_MASK, 32'h0);
      chk_reg("R9", A_MST, 32'h800);
      chk("R9", "irq unmasked", 32'(irq), 1);
      cleanup();
   endtask

   task automatic t_or();
      wr_reg(A_POL, 32'h3000); wr_reg(A_EN, 32'h3000);
      pins[12] = 1'b1;
      tick(4); chk_reg("R10", A_MST, 32'h1000);
      chk("R10", "irq one", 32'(irq), 1);
      pins[13] = 1'b1;
      tick(4); chk_reg("R10", A_MST, 32'h3000);
      wr_reg(A_CLR, 32'h1000);
      chk("R10", "irq after first clear", 32'(irq), 1);
      wr_reg(A_CLR, 32'h2000);
      chk("R10", "irq after second clear", 32'(irq), 0);
      chk_reg("R10", A_MST, 0);
      cleanup();
   endtask

   task automatic t_collide();
      wr_reg(A_BOTH, 32'h4000); wr_reg(A_EN, 32'h4000);
      pins[14] = 1'b1;
      tick(4); chk_reg("R11", A_RAW, 32'h4000);
      pins[14] = 1'b0;
      tick(2);
      wr_reg(A_CLR, 32'h4000);   // captured on the edge that raises the new event
      chk_reg("R11", A_RAW, 32'h4000);
      wr_reg(A_CLR, 32'h4000);
      chk_reg("R11", A_RAW, 0);
      cleanup();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_regmap();
      t_sync();
      t_edges();
      t_both();
      t_level();
      t_w1c();
      t_enable();
      t_mask();
      t_or();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule